// File: doc/BRIEF.md
# Triple Selectable-Ratio Clock Divider

This block takes gate-style clock pulses from outside the chip and makes three slower pulse streams from them. Each of three channels counts rising edges of its chosen input clock and emits one pulse every N of them. N is picked per channel from 1 to 8. An output pulse is gated by the incoming clock, so it is exactly as wide as the input pulse that produced it. A ratio of 1 passes every pulse straight through.

Channel 0 always listens to the first clock input. Channels 1 and 2 listen to the second clock input while a presence flag says a source is attached there, and fall back to the first input otherwise. A shared alignment input restarts all three counts together. Its rising edge opens a hold window of fixed length, counted in system-clock cycles, and every counter sits at zero for that long. All external inputs are asynchronous and are brought into a fast system clock through two-flop synchronizers. Each channel also has an indicator bit that copies its divided output.

Top module: `tri_clock_divider`

## Requirements
- R1: Each channel emits one output pulse per N rising edges of its selected input clock. N comes from that channel's 4-bit field of `ratioSel` (channel c in bits 4c+3..4c), and the three channels are independent.
- R2: A channel's counter changes only on a rising edge of its input or during a hold. On each edge it steps from state k to k+1, or to 0 when k+1 reaches N, so it cycles through 0..N-1. After reset or a hold, the first pulse comes on the Nth edge. With N = 1 every edge gives a pulse.
- R3: An output is high only while its counter is in state 0 and its selected input is high. The pulse is as wide as the input high time and lags the input pin by three system-clock cycles.
- R4: Channel 0 uses `clkIn1`. Channels 1 and 2 use `clkIn2` while `in2Present` is 1 and use `clkIn1` while it is 0.
- R5: A rising edge on `alignIn` starts a hold of `PULSE_LEN` system cycles. During the hold every counter is held at state 0 and ignores input edges, while each output still follows its input clock.
- R6: A new `alignIn` rising edge that arrives while a hold is running restarts the hold for a full `PULSE_LEN` cycles.
- R7: A change to a ratio field takes effect on that channel's next input rising edge. If the stepped count is then at or above the new N, the counter goes to state 0.
- R8: Ratio field values 0 and 9 to 15 act as N = 1.
- R9: `ledOut` equals `divOut` bit for bit at all times.
- R10: While `rstN` is low, and right after it is released, all outputs are 0 and all counters are in state 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all inputs |
| rstN | input | 1 | Asynchronous active-low reset |
| clkIn1 | input | 1 | First external clock input, asynchronous |
| clkIn2 | input | 1 | Second external clock input, asynchronous |
| in2Present | input | 1 | 1 when a source is attached to `clkIn2` |
| alignIn | input | 1 | Alignment input; its rising edge starts the hold |
| ratioSel | input | 12 | Three 4-bit ratio fields, channel 0 in bits 3..0 |
| divOut | output | 3 | Divided pulse outputs, one per channel |
| ledOut | output | 3 | Indicator bits that copy `divOut` |

## Verification
The divider is driven with input trains of different duty cycles and pulse widths under ratio sets such as {2,3,5}, {1,8,4} and {8,8,8}→{3,3,3}. Comparing the count of output pulses against edges shows a wrong modulus. Comparing pulse shape every cycle shows gating, width or latency errors that a count alone would miss. Separate trains on each input with `in2Present` toggled show whether channel routing is right. Alignment edges that land mid-train, including a second edge inside a running hold, show whether the hold zeroes the counters, keeps input edges out, and restarts its timer. Out-of-range ratio codes and a ratio cut below the current count cover the wrap-to-zero paths.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int NUM_CH    = 3;
  localparam int MAX_RATIO = 8;
  localparam int CNT_W     = $clog2(MAX_RATIO);
  localparam int SEL_W     = $clog2(MAX_RATIO) + 1;

  // strobes passed from control to datapath, one bit per channel
  typedef struct packed {
    logic [NUM_CH-1:0] level;  // selected input, aligned to output timing
    logic [NUM_CH-1:0] rise;   // one-cycle rising-edge marker
    logic              hold;   // alignment hold window active
  } divStrobe_t;

  // out-of-range codes collapse to a ratio of one
  function automatic logic [SEL_W-1:0] effRatio(input logic [SEL_W-1:0] sel);
    if (sel >= SEL_W'(1) && sel <= SEL_W'(MAX_RATIO)) return sel;
    return SEL_W'(1);
  endfunction
endpackage

// File: rtl/clkdiv_sync.sv
module clkdiv_sync (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic lvl,
  output logic lvlDly
);
  logic meta;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta   <= 1'b0;
      lvl    <= 1'b0;
      lvlDly <= 1'b0;
    end else begin
      meta   <= rawIn;
      lvl    <= meta;
      lvlDly <= lvl;
    end
  end
endmodule

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
#(
  parameter int PULSE_LEN = 50000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkIn1,
  input  logic       clkIn2,
  input  logic       in2Present,
  input  logic       alignIn,
  output divStrobe_t strobes
);
  localparam int TMR_W     = $clog2(PULSE_LEN + 1);
  localparam int N_SRC     = 4;
  localparam int IDX_IN1   = 0;
  localparam int IDX_IN2   = 1;
  localparam int IDX_PRES  = 2;
  localparam int IDX_ALIGN = 3;

  logic [N_SRC-1:0] rawVec;
  logic [N_SRC-1:0] lvlVec;
  logic [N_SRC-1:0] dlyVec;

  assign rawVec = {alignIn, in2Present, clkIn2, clkIn1};

  for (genvar s = 0; s < N_SRC; s++) begin : g_sync
    clkdiv_sync u_sync (
      .clk   (clk),
      .rstN  (rstN),
      .rawIn (rawVec[s]),
      .lvl   (lvlVec[s]),
      .lvlDly(dlyVec[s])
    );
  end

  logic             alignRise;
  logic [TMR_W-1:0] holdTmr;

  assign alignRise = lvlVec[IDX_ALIGN] & ~dlyVec[IDX_ALIGN];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                holdTmr <= '0;
    else if (alignRise)       holdTmr <= TMR_W'(PULSE_LEN);
    else if (holdTmr != '0)   holdTmr <= holdTmr - TMR_W'(1);
  end

  logic              useIn2;
  logic [NUM_CH-1:0] riseVec;
  logic [NUM_CH-1:0] levelVec;

  assign useIn2 = lvlVec[IDX_PRES];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_route
    logic srcLvl;
    logic srcDly;
    if (c == 0) begin : g_fixed
      assign srcLvl = lvlVec[IDX_IN1];
      assign srcDly = dlyVec[IDX_IN1];
    end else begin : g_shared
      assign srcLvl = useIn2 ? lvlVec[IDX_IN2] : lvlVec[IDX_IN1];
      assign srcDly = useIn2 ? dlyVec[IDX_IN2] : dlyVec[IDX_IN1];
    end
    assign riseVec[c]  = srcLvl & ~srcDly;
    assign levelVec[c] = srcDly;
  end

  assign strobes = '{level: levelVec, rise: riseVec, hold: (holdTmr != '0)};
endmodule

// File: rtl/clkdiv_datapath.sv
module clkdiv_datapath
  import clkdiv_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  divStrobe_t                strobes,
  input  logic [NUM_CH*SEL_W-1:0]   ratioSel,
  output logic [NUM_CH-1:0]         divOut,
  output logic [NUM_CH*CNT_W-1:0]   countFlat
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [SEL_W-1:0] ratioEff;
    logic [CNT_W-1:0] countQ;
    logic [SEL_W:0]   stepVal;
    logic             wrap;

    assign ratioEff = effRatio(ratioSel[c*SEL_W +: SEL_W]);
    assign stepVal  = (SEL_W+1)'(countQ) + (SEL_W+1)'(1);
    assign wrap     = stepVal >= (SEL_W+1)'(ratioEff);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                countQ <= '0;
      else if (strobes.hold)    countQ <= '0;
      else if (strobes.rise[c]) countQ <= wrap ? '0 : stepVal[CNT_W-1:0];
    end

    assign divOut[c] = (countQ == '0) & strobes.level[c];
    assign countFlat[c*CNT_W +: CNT_W] = countQ;
  end
endmodule

// File: rtl/tri_clock_divider.sv
module tri_clock_divider
  import clkdiv_pkg::*;
#(
  parameter int PULSE_LEN = 50000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clkIn1,
  input  logic                    clkIn2,
  input  logic                    in2Present,
  input  logic                    alignIn,
  input  logic [NUM_CH*SEL_W-1:0] ratioSel,
  output logic [NUM_CH-1:0]       divOut,
  output logic [NUM_CH-1:0]       ledOut
);
  divStrobe_t                strobes;
  logic [NUM_CH*CNT_W-1:0]   countFlat;

  clkdiv_ctrl #(.PULSE_LEN(PULSE_LEN)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .clkIn1    (clkIn1),
    .clkIn2    (clkIn2),
    .in2Present(in2Present),
    .alignIn   (alignIn),
    .strobes   (strobes)
  );

  clkdiv_datapath u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .ratioSel (ratioSel),
    .divOut   (divOut),
    .countFlat(countFlat)
  );

  assign ledOut = divOut;
endmodule

// File: rtl/clkdiv_checker.sv
module clkdiv_checker
  import clkdiv_pkg::*;
(
  input logic                    clk,
  input logic                    rstN,
  input logic                    clkIn1,
  input logic [NUM_CH-1:0]       divOut,
  input logic                    hold,
  input logic [NUM_CH-1:0]       rise,
  input logic                    alignRise,
  input logic [NUM_CH*CNT_W-1:0] countFlat
);
  // R3: channel 0 output implies its input pin was high three cycles earlier
  assert_out_needs_clock_R3: assert property (@(posedge clk) disable iff (!rstN)
    divOut[0] |-> $past(clkIn1, 3));

  // R5: an alignment edge opens the hold window on the next cycle
  assert_hold_starts_R5: assert property (@(posedge clk) disable iff (!rstN)
    alignRise |=> hold);

  // R5: every counter sits at zero after a hold cycle
  assert_hold_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    hold |=> (countFlat == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R2: no edge and no hold leaves the count untouched
    assert_count_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
      (!hold && !rise[c]) |=> $stable(countFlat[c*CNT_W +: CNT_W]));
  end
endmodule

bind tri_clock_divider clkdiv_checker i_checker (
  .clk      (clk),
  .rstN     (rstN),
  .clkIn1   (clkIn1),
  .divOut   (divOut),
  .hold     (strobes.hold),
  .rise     (strobes.rise),
  .alignRise(u_ctrl.alignRise),
  .countFlat(countFlat)
);

// File: tb/test_tri_clock_divider.sv
module test_tri_clock_divider;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD_LEN   = 20;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clkIn1 = 1'b0;
  logic        clkIn2 = 1'b0;
  logic        in2Present = 1'b0;
  logic        alignIn = 1'b0;
  logic [11:0] ratioSel = 12'h0;
  logic [2:0]  divOut;
  logic [2:0]  ledOut;

  int    checkCount = 0;
  int    errCount = 0;
  int    cycles = 0;
  bit    checking = 1'b0;
  bit    done = 1'b0;
  string phaseReq = "R10";

  tri_clock_divider #(.PULSE_LEN(HOLD_LEN)) i_tri_clock_divider (
    .clk(clk), .rstN(rstN), .clkIn1(clkIn1), .clkIn2(clkIn2),
    .in2Present(in2Present), .alignIn(alignIn), .ratioSel(ratioSel),
    .divOut(divOut), .ledOut(ledOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference ----------------
  bit h1[4], h2[4], hP[4], hA[4];
  int mCnt[3];
  int mTimer;
  logic [2:0] expOut;

  function automatic int ratioOf(input logic [11:0] r, input int ch);
    int v = int'(r[ch*4 +: 4]);
    return (v < 1 || v > 8) ? 1 : v;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < 4; j++) begin h1[j] = 0; h2[j] = 0; hP[j] = 0; hA[j] = 0; end
      for (int c = 0; c < 3; c++) mCnt[c] = 0;
      mTimer = 0;
      expOut = 3'b000;
    end else begin
      bit holding;
      for (int j = 3; j > 0; j--) begin
        h1[j] = h1[j-1]; h2[j] = h2[j-1]; hP[j] = hP[j-1]; hA[j] = hA[j-1];
      end
      h1[0] = clkIn1; h2[0] = clkIn2; hP[0] = in2Present; hA[0] = alignIn;
      holding = (mTimer != 0);
      for (int c = 0; c < 3; c++) begin
        bit nowLvl, oldLvl, outLvl;
        nowLvl = (c != 0 && hP[2]) ? h2[2] : h1[2];
        oldLvl = (c != 0 && hP[2]) ? h2[3] : h1[3];
        outLvl = (c != 0 && hP[1]) ? h2[2] : h1[2];
        if (holding) mCnt[c] = 0;
        else if (nowLvl && !oldLvl)
          mCnt[c] = (mCnt[c] + 1 >= ratioOf(ratioSel, c)) ? 0 : mCnt[c] + 1;
        expOut[c] = (mCnt[c] == 0) && outLvl;
      end
      if (hA[2] && !hA[3]) mTimer = HOLD_LEN;
      else if (mTimer > 0) mTimer--;
    end
  end

  // ---------------- per-cycle comparison ----------------
  int outRises[3];
  logic [2:0] prevOut = 3'b000;

  always @(negedge clk) begin
    if (rstN && checking && !done) begin
      for (int c = 0; c < 3; c++) begin
        checkCount++;
        if (divOut[c] !== expOut[c]) begin
          errCount++;
          $display("FAIL %s divOut[%0d] actual %0b expected %0b at cycle %0d",
                   phaseReq, c, divOut[c], expOut[c], cycles);
        end
        if (divOut[c] && !prevOut[c]) outRises[c]++;
      end
      checkCount++;
      if (ledOut !== divOut) begin
        errCount++;
        $display("FAIL R9 ledOut actual %b expected %b", ledOut, divOut);
      end
      prevOut = divOut;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      errCount++;
      $display("FAIL R1 watchdog expired actual %0d expected below %0d cycles", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checkCount, errCount);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseTrain(input int hi, input int lo, input int n, input bit on1, input bit on2);
    for (int p = 0; p < n; p++) begin
      @(negedge clk);
      if (on1) clkIn1 = 1'b1;
      if (on2) clkIn2 = 1'b1;
      repeat (hi - 1) @(negedge clk);
      @(negedge clk);
      clkIn1 = 1'b0;
      clkIn2 = 1'b0;
      repeat (lo - 1) @(negedge clk);
    end
  endtask

  task automatic alignPulse();
    @(negedge clk);
    alignIn = 1'b1;
    repeat (3) @(negedge clk);
    alignIn = 1'b0;
  endtask

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    checkCount++;
    if (act != exp) begin
      errCount++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    ratioSel = {4'd5, 4'd3, 4'd2};
    idle(3);
    // R10: outputs low while reset is held
    checkEq("R10", "divOut during reset", int'(divOut), 0);
    checkEq("R10", "ledOut during reset", int'(ledOut), 0);
    @(negedge clk);
    rstN = 1'b1;
    checking = 1'b1;
    idle(4);
    checkEq("R10", "divOut after release", int'(divOut), 0);

    // R1: pulse counts for ratios 2, 3, 5 over 30 input edges
    phaseReq = "R1";
    for (int c = 0; c < 3; c++) outRises[c] = 0;
    pulseTrain(4, 6, 30, 1'b1, 1'b0);
    idle(10);
    checkEq("R1", "pulses ch0 ratio 2", outRises[0], 15);
    checkEq("R1", "pulses ch1 ratio 3", outRises[1], 10);
    checkEq("R1", "pulses ch2 ratio 5", outRises[2], 6);

    // R2 / R3: ratios 1, 8, 4 with short and long high phases
    phaseReq = "R3";
    ratioSel = {4'd4, 4'd8, 4'd1};
    pulseTrain(2, 3, 20, 1'b1, 1'b0);
    phaseReq = "R2";
    pulseTrain(7, 2, 16, 1'b1, 1'b0);
    idle(6);

    // R4: second input routing
    phaseReq = "R4";
    in2Present = 1'b1;
    idle(5);
    pulseTrain(3, 3, 20, 1'b0, 1'b1);
    pulseTrain(3, 3, 10, 1'b1, 1'b0);
    in2Present = 1'b0;
    idle(5);
    pulseTrain(3, 3, 6, 1'b0, 1'b1);
    idle(5);

    // R8: out-of-range codes behave as ratio one
    phaseReq = "R8";
    ratioSel = {4'd9, 4'd12, 4'd0};
    pulseTrain(3, 2, 12, 1'b1, 1'b0);
    idle(5);

    // R7: cut the ratio below the running count
    phaseReq = "R7";
    ratioSel = {4'd8, 4'd8, 4'd8};
    pulseTrain(2, 2, 5, 1'b1, 1'b0);
    ratioSel = {4'd3, 4'd3, 4'd3};
    pulseTrain(2, 2, 9, 1'b1, 1'b0);
    idle(5);

    // R5: hold during a running train
    phaseReq = "R5";
    ratioSel = {4'd4, 4'd3, 4'd2};
    alignPulse();
    pulseTrain(2, 2, 8, 1'b1, 1'b0);
    pulseTrain(2, 2, 8, 1'b1, 1'b0);
    idle(5);

    // R6: second alignment edge inside an active hold
    phaseReq = "R6";
    alignPulse();
    pulseTrain(2, 2, 3, 1'b1, 1'b0);
    alignPulse();
    pulseTrain(2, 2, 12, 1'b1, 1'b0);
    idle(10);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checkCount, errCount);
    $finish;
  end
endmodule